// File: doc/BRIEF.md
# Nibble-Serial GF(2^128) Table Multiplier

This block multiplies two 128-bit elements of GF(2^128) in the bit-reflected convention used by GHASH. Each value on a bus has byte 0 of its byte string in bits 127:120. Bit 127 holds the coefficient of x^0 and bit 0 holds the coefficient of x^127. The field polynomial is x^128 + x^7 + x^2 + x + 1. One cycle of `loadKey` captures a key H. The block then spends 15 cycles building a register table that holds the 16 products of H with every 4-bit polynomial.

A one-cycle `start` then multiplies an operand X by that key. The block uses one nibble of X per cycle, beginning with bus bits 3:0 and moving upward four bits at a time. The first nibble loads the accumulator straight from the table. Every later nibble does three things:
- shifts the accumulator right by four;
- adds the table entry for that nibble;
- folds the four shifted-out bits back in through a 16-entry, 16-bit remainder table applied to the top 16 bits.

After 32 nibbles the product appears on `result` with a one-cycle `done`.

A typical use is as the hash multiplier of an authenticated-encryption engine. The engine loads its hash key once and then issues one multiply per block.

Top module: `gmul_nibble`

## Requirements
- R1: While and after reset, `busy` and `done` are 0 and `result` is all zeros.
- R2: A `loadKey` sampled high while idle makes `busy` high for exactly the next 15 cycles. The block then returns to idle with the new key in use.
- R3: A multiply that completes returns `result` = X·H in the convention above. X is the `dataX` value sampled with the accepted `start`, and H is the most recently accepted key, or zero if no key has been loaded. `result` then holds until the next accepted `start`.
- R4: `done` is high for exactly one cycle. That cycle follows the 31st rising edge after the edge that accepted `start`, so a bench that counts from the cycle after the `start` pulse sees it in cycle 32. `busy` is high for the 31 cycles in between and low while `done` is high.
- R5: A `start` that arrives while `busy` is high is ignored. It changes neither the running result nor the time at which `done` appears.
- R6: A `loadKey` that arrives during a multiply is ignored. The current product and later products keep the old key.
- R7: If `loadKey` and `start` are high in the same idle cycle, the key load wins and the `start` is dropped. No `done` follows and `result` is unchanged.
- R8: An operand X of zero gives zero. A key H of zero gives zero for any X.
- R9: A key equal to the field identity gives `result` = X. The identity has only bit 127 set.
- R10: Loading a new key replaces every table entry. The next multiply uses only the new key.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| loadKey | input | 1 | One-cycle strobe that captures `keyH` and builds the table |
| keyH | input | 128 | Hash key H |
| start | input | 1 | One-cycle strobe that begins a multiply of `dataX` by H |
| dataX | input | 128 | Operand X |
| busy | output | 1 | High while the table is being built or a multiply runs |
| done | output | 1 | One-cycle pulse when `result` holds a new product |
| result | output | 128 | Product X·H, held until the next accepted multiply |

## Verification
A key accepted at one rising edge keeps `busy` high in the 15 cycles after it. A `start` accepted at edge S0 gives `done` and the final product in the cycle after edge S31, so `done` is seen 32 sampling points after the start pulse. The bench drives inputs on falling edges and updates a behavioural model on every rising edge. The model uses a countdown of remaining busy cycles and a bit-serial reference product. On each falling edge the bench compares `busy`, `done` and, whenever the model is idle, `result`. The partial accumulator during a multiply is never compared. Directed checks also count the latency cycles and check known products: zero operands, the identity key and a published hash-key vector.

// File: rtl/gmul_pkg.sv
package gmul_pkg;
  localparam int BLK_W  = 128;
  localparam int NIB_W  = 4;
  localparam int TBL_N  = 1 << NIB_W;
  localparam int STEPS  = BLK_W / NIB_W;
  localparam int CNT_W  = $clog2(STEPS);
  localparam int REM_W  = 16;
  localparam logic [7:0] POLY = 8'hE1;

  typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_MUL} stateT;

  typedef struct packed {
    logic             keyInit;
    logic             preStep;
    logic [NIB_W-1:0] preIdx;
    logic             mulFirst;
    logic             mulStep;
  } ctlT;

  // multiply by x in the reflected convention: shift toward bit 0, fold
  function automatic logic [BLK_W-1:0] mulX(input logic [BLK_W-1:0] v);
    return (v >> 1) ^ ({BLK_W{v[0]}} & {POLY, {(BLK_W-8){1'b0}}});
  endfunction

  // remainder pattern for NIB_W bits dropped off the low end
  function automatic logic [REM_W-1:0] remOf(input logic [NIB_W-1:0] idx);
    logic [BLK_W-1:0] v;
    v = {{(BLK_W-NIB_W){1'b0}}, idx};
    for (int k = 0; k < NIB_W; k++) v = mulX(v);
    return v[BLK_W-1 -: REM_W];
  endfunction
endpackage

// File: rtl/gmul_ctrl.sv
module gmul_ctrl
  import gmul_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic loadKey,
  input  logic start,
  output ctlT  ctl,
  output logic busy,
  output logic done
);
  stateT            state;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    ctl          = '0;
    ctl.keyInit  = (state == ST_IDLE) && loadKey;
    ctl.mulFirst = (state == ST_IDLE) && !loadKey && start;
    ctl.preStep  = (state == ST_PRE);
    ctl.preIdx   = cnt[NIB_W-1:0];
    ctl.mulStep  = (state == ST_MUL);
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (ctl.keyInit) begin
            state <= ST_PRE;
            cnt   <= CNT_W'(1);
          end else if (ctl.mulFirst) begin
            state <= ST_MUL;
            cnt   <= CNT_W'(1);
          end
        end
        ST_PRE: begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(TBL_N - 1)) state <= ST_IDLE;
        end
        ST_MUL: begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(STEPS - 1)) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/gmul_dpath.sv
module gmul_dpath
  import gmul_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctlT              ctl,
  input  logic [BLK_W-1:0] keyH,
  input  logic [BLK_W-1:0] dataX,
  output logic [BLK_W-1:0] acc
);
  logic [BLK_W-1:0] tbl [TBL_N];
  logic [BLK_W-1:0] pw  [NIB_W];
  logic [BLK_W-1:0] newEntry;
  logic [BLK_W-1:0] xReg;
  logic [BLK_W-1:0] stepVal;

  // powers: pw[b] is the table entry for index 2^b
  assign pw[NIB_W-1] = tbl[TBL_N/2];
  for (genvar b = 0; b < NIB_W - 1; b++) begin : g_pow
    assign pw[b] = mulX(pw[b+1]);
  end

  always_comb begin
    newEntry = '0;
    for (int b = 0; b < NIB_W; b++)
      if (ctl.preIdx[b]) newEntry = newEntry ^ pw[b];
  end

  assign stepVal = (acc >> NIB_W) ^ tbl[xReg[NIB_W-1:0]]
                 ^ {remOf(acc[NIB_W-1:0]), {(BLK_W-REM_W){1'b0}}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < TBL_N; i++) tbl[i] <= '0;
      acc  <= '0;
      xReg <= '0;
    end else begin
      if (ctl.keyInit) begin
        tbl[0]       <= '0;
        tbl[TBL_N/2] <= keyH;
      end
      if (ctl.preStep) tbl[ctl.preIdx] <= newEntry;
      if (ctl.mulFirst) begin
        acc  <= tbl[dataX[NIB_W-1:0]];
        xReg <= dataX >> NIB_W;
      end
      if (ctl.mulStep) begin
        acc  <= stepVal;
        xReg <= xReg >> NIB_W;
      end
    end
  end
endmodule

// File: rtl/gmul_nibble.sv
module gmul_nibble
  import gmul_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         loadKey,
  input  logic [127:0] keyH,
  input  logic         start,
  input  logic [127:0] dataX,
  output logic         busy,
  output logic         done,
  output logic [127:0] result
);
  ctlT ctl;

  gmul_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .loadKey(loadKey), .start(start),
    .ctl(ctl), .busy(busy), .done(done)
  );

  gmul_dpath u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .keyH(keyH), .dataX(dataX),
    .acc(result)
  );
endmodule

// File: rtl/gmul_nibble_chk.sv
module gmul_nibble_chk
  import gmul_pkg::*;
(
  input logic         clk,
  input logic         rstN,
  input logic         loadKey,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [127:0] result
);
  localparam int MC_W = $clog2(STEPS + 1);
  logic [MC_W-1:0] mcnt;

  // counts cycles since an accepted multiply request
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) mcnt <= '0;
    else if (!busy && start && !loadKey) mcnt <= MC_W'(1);
    else if (done) mcnt <= '0;
    else if (mcnt != '0) mcnt <= mcnt + 1'b1;
  end

  a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r4_done_latency: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (mcnt == MC_W'(STEPS)));

  a_r4_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  a_r2_key_busy: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && loadKey) |=> busy);

  a_r3_result_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(result));

  a_r7_key_wins: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && loadKey) |=> $stable(result));
endmodule

bind gmul_nibble gmul_nibble_chk u_chk (.*);

// File: tb/gmul_nibble_tb.sv
module gmul_nibble_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;
  localparam int PRE_CYC    = 15;
  localparam int MUL_CYC    = 31;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         loadKey = 1'b0;
  logic [127:0] keyH = '0;
  logic         start = 1'b0;
  logic [127:0] dataX = '0;
  logic         busy, done;
  logic [127:0] result;

  int  total = 0;
  int  bad = 0;
  int  cyc = 0;
  bit  finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gmul_nibble dut_i (
    .clk(clk), .rstN(rstN), .loadKey(loadKey), .keyH(keyH),
    .start(start), .dataX(dataX), .busy(busy), .done(done), .result(result)
  );

  function automatic logic [127:0] refMul(input logic [127:0] x, input logic [127:0] h);
    logic [127:0] z = '0;
    logic [127:0] v = h;
    for (int i = 0; i < 128; i++) begin
      if (x[127-i]) z ^= v;
      v = v[0] ? ((v >> 1) ^ {8'hE1, 120'h0}) : (v >> 1);
    end
    return z;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  // behavioural model, advanced on every rising edge
  int           mRem = 0;
  bit           mMul = 1'b0;
  bit           mDone = 1'b0;
  logic [127:0] mRes = '0, mKey = '0, mPend = '0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mRem = 0; mMul = 0; mDone = 0; mRes = '0; mKey = '0;
    end else begin
      mDone = 0;
      if (mRem > 0) begin
        mRem--;
        if (mRem == 0 && mMul) begin mDone = 1; mRes = mPend; end
      end else if (loadKey) begin
        mRem = PRE_CYC; mMul = 0; mKey = keyH;
      end else if (start) begin
        mRem = MUL_CYC; mMul = 1; mPend = refMul(dataX, mKey);
      end
    end
  end

  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk(busy == (mRem > 0), "R2", "busy vs model", 128'(busy), 128'(mRem > 0));
      chk(done == mDone, "R4", "done vs model", 128'(done), 128'(mDone));
      if (mRem == 0) chk(result == mRes, "R3", "result vs model", result, mRes);
    end
  end

  task automatic finish_run();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !finished) begin
      bad++; total++;
      $display("FAIL R4 watchdog: cycles=%0d expected below %0d", cyc, WATCHDOG);
      finish_run();
    end
  end

  task automatic doLoad(input logic [127:0] k);
    @(negedge clk); loadKey = 1'b1; keyH = k;
    @(negedge clk); loadKey = 1'b0;
    while (busy) @(negedge clk);
  endtask

  task automatic runMul(input logic [127:0] x, output int lat);
    @(negedge clk); start = 1'b1; dataX = x;
    @(negedge clk); start = 1'b0;
    lat = 1;
    while (!done && lat < 100) begin @(negedge clk); lat++; end
  endtask

  logic [127:0] tvH  = 128'h66e94bd4ef8a2c3b884cfa59ca342b2e;
  logic [127:0] tvX  = 128'h0388dace60b6a392f328c2b971b2fe78;
  logic [127:0] tvZ  = 128'h5e2ec746917062882c85b0685353deb7;
  logic [127:0] oneH = {1'b1, 127'h0};

  initial begin
    int lat;
    int bcnt;
    logic [127:0] x1, x2, k2, held;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy == 1'b0, "R1", "busy in reset", 128'(busy), 128'h0);
    chk(done == 1'b0, "R1", "done in reset", 128'(done), 128'h0);
    chk(result == '0, "R1", "result in reset", result, '0);
    rstN = 1'b1;
    @(negedge clk);
    chk(result == '0, "R1", "result after reset", result, '0);

    // R2: key load occupies exactly 15 cycles
    @(negedge clk); loadKey = 1'b1; keyH = tvH;
    @(negedge clk); loadKey = 1'b0;
    bcnt = 0;
    while (busy && bcnt < 100) begin bcnt++; @(negedge clk); end
    chk(bcnt == PRE_CYC, "R2", "key busy cycles", 128'(bcnt), 128'(PRE_CYC));

    // R3 R4: published vector and latency
    runMul(tvX, lat);
    chk(lat == MUL_CYC + 1, "R4", "done latency", 128'(lat), 128'(MUL_CYC + 1));
    chk(result == tvZ, "R3", "known vector", result, tvZ);
    @(negedge clk);
    chk(done == 1'b0, "R4", "done one cycle", 128'(done), 128'h0);

    // R8: zero operand
    runMul('0, lat);
    chk(result == '0, "R8", "X zero", result, '0);

    // R3: several operands
    for (int i = 0; i < 6; i++) begin
      x1 = {$urandom, $urandom, $urandom, $urandom};
      if (i == 0) x1 = '1;
      if (i == 1) x1 = 128'h1;
      runMul(x1, lat);
      chk(result == refMul(x1, tvH), "R3", "operand sweep", result, refMul(x1, tvH));
    end

    // R5: start while busy is ignored
    x1 = 128'h0123456789abcdeffedcba9876543210;
    x2 = 128'hdeadbeef00000000cafef00d12345678;
    @(negedge clk); start = 1'b1; dataX = x1;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    start = 1'b1; dataX = x2;
    @(negedge clk); start = 1'b0;
    lat = 5;
    while (!done && lat < 100) begin @(negedge clk); lat++; end
    chk(lat == MUL_CYC + 1, "R5", "latency with extra start", 128'(lat), 128'(MUL_CYC + 1));
    chk(result == refMul(x1, tvH), "R5", "extra start ignored", result, refMul(x1, tvH));
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R5", "no second run", 128'(busy), 128'h0);

    // R6: key load during multiply is ignored
    k2 = 128'hb83b533708bf535d0aa6e52980d53b78;
    @(negedge clk); start = 1'b1; dataX = x2;
    @(negedge clk); start = 1'b0;
    repeat (4) @(negedge clk);
    loadKey = 1'b1; keyH = k2;
    @(negedge clk); loadKey = 1'b0;
    while (!done) @(negedge clk);
    chk(result == refMul(x2, tvH), "R6", "product keeps old key", result, refMul(x2, tvH));
    runMul(x1, lat);
    chk(result == refMul(x1, tvH), "R6", "later product old key", result, refMul(x1, tvH));

    // R7: simultaneous load and start, load wins
    held = result;
    @(negedge clk); loadKey = 1'b1; keyH = k2; start = 1'b1; dataX = x2;
    @(negedge clk); loadKey = 1'b0; start = 1'b0;
    bcnt = 0;
    while (busy && bcnt < 100) begin bcnt++; @(negedge clk); end
    chk(bcnt == PRE_CYC, "R7", "load taken", 128'(bcnt), 128'(PRE_CYC));
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R7", "no done after dropped start", 128'(done), 128'h0);
    chk(result == held, "R7", "result unchanged", result, held);

    // R10: new key fully replaces old table
    runMul(x2, lat);
    chk(result == refMul(x2, k2), "R10", "new key product", result, refMul(x2, k2));
    runMul(128'hffff0000ffff0000ffff0000ffff0000, lat);
    chk(result == refMul(128'hffff0000ffff0000ffff0000ffff0000, k2), "R10",
        "new key all nibbles", result, refMul(128'hffff0000ffff0000ffff0000ffff0000, k2));

    // R8: zero key
    doLoad('0);
    runMul(x1, lat);
    chk(result == '0, "R8", "H zero", result, '0);

    // R9: identity key
    doLoad(oneH);
    runMul(x1, lat);
    chk(result == x1, "R9", "identity key", result, x1);
    runMul(tvX, lat);
    chk(result == tvX, "R9", "identity key vector", result, tvX);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule